// File: doc/BRIEF.md
# Low-Power Wakeup Event Controller

This block gathers every digital wakeup source that a low-power controller needs while the CPU sleeps. It watches two banks of dedicated GPIO pins and a small set of peripheral event lines: USB line state, USB bus power, DMA, four analog comparator outputs, battery-backup exit and reset detect. It keeps a sticky flag for each event and masks the flags with per-source enables and with two global class enables. It drives a single level interrupt that wakes the CPU.

Software reaches the flags and enables through a small synchronous register port. Flags are cleared by writing ones. The peripheral status word also shows the four comparator outputs as live read-only levels. All event inputs are asynchronous and are synchronized inside the block. The two global enables, `gpio_wake_en` and `usb_wake_en`, are synchronous inputs and act on the interrupt at once.

Top module: `lp_wake_ctrl`

## Requirements
- R1: A GPIO status bit sets when its synchronized pin changes level in either direction, whether or not the pin is enabled. Bank 0 has 32 pins and bank 1 has 18 pins.
- R2: Writing 1 to a sticky status bit clears it. Writing 0 leaves it unchanged.
- R3: A GPIO status bit adds to the interrupt only when its per-pin enable bit is 1 and `gpio_wake_en` is high.
- R4: Reads with `rd_en` high return these registers: 0x04 bank 0 status, 0x08 bank 0 enable, 0x0C bank 1 status, 0x10 bank 1 enable, 0x30 peripheral status, 0x34 peripheral enable. Unused bits and every other offset read as zero. With `rd_en` low, `rdata` is zero.
- R5: The peripheral status bits are laid out as follows. Bits 1:0 are USB line-state wake and bit 2 is bus-power wake; these set on either edge. Bit 3 is DMA wake and sets on a rising edge. Bits 7:4 are comparator 0 to 3 wake and set on either edge of the comparator output. Bit 16 is battery-backup exit and bit 17 is reset detect; both set on a rising edge.
- R6: Peripheral status bits 11:8 show the synchronized comparator 0 to 3 outputs. They are not sticky and ignore writes.
- R7: Peripheral enable bits 7:0 gate status bits 7:0. Bits 1:0 also need `usb_wake_en` high. Status bits 16 and 17 never raise the interrupt.
- R8: Each event input passes through two flops. A status flag becomes readable after the third rising clock edge that follows an input change. A comparator level becomes readable after the second such edge.
- R9: If an event and a write-one-to-clear reach the same bit in the same cycle, the bit stays set.
- R10: After reset, every status and enable register reads zero and `wake_irq` is low.
- R11: `wake_irq` is the OR of all enabled status bits that are set. It stays high until software clears those bits or removes their enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio0_in | input | 32 | Bank 0 wake pins (asynchronous) |
| gpio1_in | input | 18 | Bank 1 wake pins (asynchronous) |
| usb_ls_in | input | 2 | USB line-state signals |
| usb_vbus_in | input | 1 | USB bus-power present |
| dma_evt_in | input | 1 | DMA wake request |
| cmp_in | input | 4 | Analog comparator outputs 0 to 3 |
| bbu_exit_in | input | 1 | Battery-backup exit indication |
| rst_det_in | input | 1 | Reset-detect indication |
| gpio_wake_en | input | 1 | Global enable for GPIO wake |
| usb_wake_en | input | 1 | Global enable for USB line-state wake |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data |
| wake_irq | output | 1 | Wakeup interrupt, level |

## Verification
The hardest case to reach from the ports is a clear and an event landing on the same bit in the same cycle. The event reaches the status register only after the synchronizer and the edge-detect flop. The bench therefore toggles a pin on a falling clock edge and waits exactly two falling edges. It then holds an all-ones clear on that bank across the rising edge where the flag is captured. Another bit of the same bank is already set, so the test shows both sides: that bit clears and the colliding bit stays set. The synchronizer latency is checked cycle by cycle in the same way. Constrained random pin and peripheral toggles, enable writes, masked clears and global enable changes cover the rest.

// File: rtl/lp_wake_pkg.sv
package lp_wake_pkg;
    localparam int unsigned REG_W  = 32;
    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_G0_STAT = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_G0_MASK = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_G1_STAT = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_G1_MASK = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_PR_STAT = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_PR_MASK = 8'h34;

    // peripheral sources in internal order: ls[1:0], vbus, dma, cmp[3:0], bbu, rst
    localparam int unsigned PR_SRC_N  = 10;
    localparam int unsigned PR_MASK_W = 8;
    localparam int unsigned CMP_N     = 4;
    localparam int unsigned POS_LVL   = 8;
    localparam int unsigned POS_BBU   = 16;
    localparam int unsigned POS_RSD   = 17;
    // 1 = either edge sets the flag, 0 = rising edge only
    localparam logic [PR_SRC_N-1:0] PR_ANY_EDGE = 10'b00_1111_0111;
endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.meta   = async_i;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_o = s_q.stable;

    // R8: output trails the input by two clock edges
    p_two_stage_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ##1 (sync_o == $past(async_i, 2)));
endmodule

// File: rtl/wk_gpio_bank.sv
module wk_gpio_bank #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_s,
    input  logic         wr_stat,
    input  logic         wr_mask,
    input  logic [W-1:0] wdata,
    input  logic         glb_en,
    output logic [W-1:0] stat_o,
    output logic [W-1:0] mask_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] stat;
        logic [W-1:0] mask;
    } bank_t;

    bank_t b_d, b_q;
    logic [W-1:0] evt;

    always_comb begin
        b_d      = b_q;
        evt      = pin_s ^ b_q.prev;
        b_d.prev = pin_s;
        if (wr_stat) b_d.stat = b_q.stat & ~wdata;
        b_d.stat = b_d.stat | evt;
        if (wr_mask) b_d.mask = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign stat_o = b_q.stat;
    assign mask_o = b_q.mask;
    assign irq_o  = glb_en & (|(b_q.stat & b_q.mask));

    p_edge_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((stat_o & $past(evt)) == $past(evt)));
    p_w1c_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> ((stat_o & $past(wdata & ~evt)) == '0));
    p_zero_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> ((stat_o & $past(stat_o & ~wdata)) == $past(stat_o & ~wdata)));
    p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_o & ~$past(stat_o) & ~$past(evt)) == '0));
    p_irq_glb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |-> !irq_o);
    p_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && |(wdata & evt)) |=> ((stat_o & $past(wdata & evt)) == $past(wdata & evt)));
endmodule

// File: rtl/wk_periph.sv
module wk_periph
    import lp_wake_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PR_SRC_N-1:0]   src_s,
    input  logic                  wr_stat,
    input  logic                  wr_mask,
    input  logic [PR_SRC_N-1:0]   clr_bits,
    input  logic [PR_MASK_W-1:0]  mask_wd,
    input  logic                  usb_en,
    output logic [REG_W-1:0]      stat_word,
    output logic [REG_W-1:0]      mask_word,
    output logic                  irq_o
);
    typedef struct packed {
        logic [PR_SRC_N-1:0]  prev;
        logic [PR_SRC_N-1:0]  flag;
        logic [PR_MASK_W-1:0] mask;
    } pr_t;

    pr_t p_d, p_q;
    logic [PR_SRC_N-1:0] toggled, rose, evt;

    always_comb begin
        p_d     = p_q;
        toggled = src_s ^ p_q.prev;
        rose    = src_s & ~p_q.prev;
        evt     = (toggled & PR_ANY_EDGE) | (rose & ~PR_ANY_EDGE);
        p_d.prev = src_s;
        if (wr_stat) p_d.flag = p_q.flag & ~clr_bits;
        p_d.flag = p_d.flag | evt;
        if (wr_mask) p_d.mask = mask_wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_comb begin
        stat_word = '0;
        stat_word[PR_MASK_W-1:0]           = p_q.flag[PR_MASK_W-1:0];
        stat_word[POS_LVL +: CMP_N]        = src_s[4 +: CMP_N];
        stat_word[POS_BBU]                 = p_q.flag[8];
        stat_word[POS_RSD]                 = p_q.flag[9];
        mask_word = '0;
        mask_word[PR_MASK_W-1:0]           = p_q.mask;
    end

    assign irq_o = (|(p_q.flag[7:2] & p_q.mask[7:2]))
                 | (usb_en & (|(p_q.flag[1:0] & p_q.mask[1:0])));

    p_usb_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!usb_en && ((stat_word[7:2] & mask_word[7:2]) == '0)) |-> !irq_o);
    p_tail_no_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_word[7:0] & mask_word[7:0]) == '0) |-> !irq_o);
    p_dma_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(src_s[3]) && !stat_word[3]) |=> !stat_word[3]);
    p_bbu_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && clr_bits[8] && !evt[8]) |=> !stat_word[POS_BBU]);
endmodule

// File: rtl/lp_wake_ctrl.sv
module lp_wake_ctrl
    import lp_wake_pkg::*;
#(
    parameter int unsigned G0_W = 32,
    parameter int unsigned G1_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [G0_W-1:0]   gpio0_in,
    input  logic [G1_W-1:0]   gpio1_in,
    input  logic [1:0]        usb_ls_in,
    input  logic              usb_vbus_in,
    input  logic              dma_evt_in,
    input  logic [CMP_N-1:0]  cmp_in,
    input  logic              bbu_exit_in,
    input  logic              rst_det_in,
    input  logic              gpio_wake_en,
    input  logic              usb_wake_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [REG_W-1:0]  rdata,
    output logic              wake_irq
);
    localparam int unsigned ALL_W = G0_W + G1_W + PR_SRC_N;

    logic [ALL_W-1:0]    raw, synced;
    logic [G0_W-1:0]     g0_stat, g0_mask;
    logic [G1_W-1:0]     g1_stat, g1_mask;
    logic [REG_W-1:0]    pr_stat, pr_mask;
    logic                g0_irq, g1_irq, pr_irq;
    logic [PR_SRC_N-1:0] pr_clr;

    assign raw = {rst_det_in, bbu_exit_in, cmp_in, dma_evt_in, usb_vbus_in, usb_ls_in,
                  gpio1_in, gpio0_in};

    wk_sync #(.W(ALL_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw), .sync_o(synced)
    );

    wk_gpio_bank #(.W(G0_W)) u_g0 (
        .clk(clk), .rst_n(rst_n), .pin_s(synced[G0_W-1:0]),
        .wr_stat(wr_en && addr == OFF_G0_STAT), .wr_mask(wr_en && addr == OFF_G0_MASK),
        .wdata(wdata[G0_W-1:0]), .glb_en(gpio_wake_en),
        .stat_o(g0_stat), .mask_o(g0_mask), .irq_o(g0_irq)
    );

    wk_gpio_bank #(.W(G1_W)) u_g1 (
        .clk(clk), .rst_n(rst_n), .pin_s(synced[G0_W +: G1_W]),
        .wr_stat(wr_en && addr == OFF_G1_STAT), .wr_mask(wr_en && addr == OFF_G1_MASK),
        .wdata(wdata[G1_W-1:0]), .glb_en(gpio_wake_en),
        .stat_o(g1_stat), .mask_o(g1_mask), .irq_o(g1_irq)
    );

    assign pr_clr = {wdata[POS_RSD], wdata[POS_BBU], wdata[PR_MASK_W-1:0]};

    wk_periph u_pr (
        .clk(clk), .rst_n(rst_n), .src_s(synced[G0_W+G1_W +: PR_SRC_N]),
        .wr_stat(wr_en && addr == OFF_PR_STAT), .wr_mask(wr_en && addr == OFF_PR_MASK),
        .clr_bits(pr_clr), .mask_wd(wdata[PR_MASK_W-1:0]), .usb_en(usb_wake_en),
        .stat_word(pr_stat), .mask_word(pr_mask), .irq_o(pr_irq)
    );

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                OFF_G0_STAT: rdata[G0_W-1:0] = g0_stat;
                OFF_G0_MASK: rdata[G0_W-1:0] = g0_mask;
                OFF_G1_STAT: rdata[G1_W-1:0] = g1_stat;
                OFF_G1_MASK: rdata[G1_W-1:0] = g1_mask;
                OFF_PR_STAT: rdata           = pr_stat;
                OFF_PR_MASK: rdata           = pr_mask;
                default:     rdata           = '0;
            endcase
        end
    end

    assign wake_irq = g0_irq | g1_irq | pr_irq;

    p_idle_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0));
    p_unmapped_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr != OFF_G0_STAT && addr != OFF_G0_MASK && addr != OFF_G1_STAT &&
         addr != OFF_G1_MASK && addr != OFF_PR_STAT && addr != OFF_PR_MASK) |-> (rdata == '0));
    p_irq_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_irq && !wr_en) |=> (wake_irq || $fell(gpio_wake_en) || $fell(usb_wake_en)));
endmodule

// File: tb/test_lp_wake_ctrl.sv
module test_lp_wake_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] g0_i = '0;
    logic [17:0] g1_i = '0;
    logic [1:0]  ls_i = '0;
    logic        vbus_i = 1'b0, dma_i = 1'b0, bb_i = 1'b0, rsd_i = 1'b0;
    logic [3:0]  cmp_i = '0;
    logic        gwen = 1'b0, uwen = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] rdata;
    logic        wake_irq;

    logic [31:0] m_g0 = '0, m_g0en = '0;
    logic [17:0] m_g1 = '0, m_g1en = '0;
    logic [9:0]  m_ps = '0;
    logic [7:0]  m_pen = '0;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lp_wake_ctrl i_lp_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .gpio0_in(g0_i), .gpio1_in(g1_i), .usb_ls_in(ls_i),
        .usb_vbus_in(vbus_i), .dma_evt_in(dma_i), .cmp_in(cmp_i), .bbu_exit_in(bb_i),
        .rst_det_in(rsd_i), .gpio_wake_en(gwen), .usb_wake_en(uwen), .addr(addr),
        .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .wake_irq(wake_irq)
    );

    function automatic logic [31:0] exp_reg(input logic [7:0] a);
        case (a)
            8'h04: return m_g0;
            8'h08: return m_g0en;
            8'h0C: return {14'b0, m_g1};
            8'h10: return {14'b0, m_g1en};
            8'h30: return {14'b0, m_ps[9:8], 4'b0, cmp_i, m_ps[7:0]};
            8'h34: return {24'b0, m_pen};
            default: return 32'b0;
        endcase
    endfunction

    function automatic logic exp_irq();
        return (gwen && |(m_g0 & m_g0en)) || (gwen && |(m_g1 & m_g1en)) ||
               (|(m_ps[7:2] & m_pen[7:2])) || (uwen && |(m_ps[1:0] & m_pen[1:0]));
    endfunction

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] v);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        rd_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input string tag);
        logic [31:0] v;
        @(negedge clk);
        peek(a, v);
        chk(v, exp_reg(a), tag);
    endtask

    task automatic irq_chk(input string tag);
        @(negedge clk);
        #1 chk({31'b0, wake_irq}, {31'b0, exp_irq()}, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            8'h04: m_g0 &= ~d;
            8'h08: m_g0en = d;
            8'h0C: m_g1 &= ~d[17:0];
            8'h10: m_g1en = d[17:0];
            8'h30: m_ps &= ~{d[17], d[16], d[7:0]};
            8'h34: m_pen = d[7:0];
            default: ;
        endcase
    endtask

    // change inputs, wait until the flags are visible, then update the model (R5, R8)
    task automatic drive_in(input logic [31:0] a, input logic [17:0] b, input logic [1:0] l,
                            input logic v, input logic d, input logic [3:0] c,
                            input logic bb, input logic r);
        logic [9:0] ev;
        @(negedge clk);
        ev = {r & ~rsd_i, bb & ~bb_i, c ^ cmp_i, d & ~dma_i, v ^ vbus_i, l ^ ls_i};
        m_g0 |= a ^ g0_i;
        m_g1 |= b ^ g1_i;
        g0_i = a; g1_i = b; ls_i = l; vbus_i = v; dma_i = d; cmp_i = c; bb_i = bb; rsd_i = r;
        repeat (3) @(negedge clk);
        m_ps |= ev;
    endtask

    task automatic clear_all();
        wr(8'h04, '1); wr(8'h0C, '1); wr(8'h30, '1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd7));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        rd_chk(8'h04, "R10"); rd_chk(8'h08, "R10"); rd_chk(8'h0C, "R10");
        rd_chk(8'h10, "R10"); rd_chk(8'h30, "R10"); rd_chk(8'h34, "R10");
        irq_chk("R10");

        // R4: unmapped offsets and idle read port
        rd_chk(8'h00, "R4"); rd_chk(8'h14, "R4"); rd_chk(8'h38, "R4"); rd_chk(8'hFC, "R4");
        @(negedge clk); addr = 8'h08; rd_en = 1'b0;
        #1 chk(rdata, 32'b0, "R4 idle");

        // R1: transitions latch with enables off
        drive_in(32'h8000_0001, 18'h2_0001, 2'b00, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0);
        rd_chk(8'h04, "R1 rise"); rd_chk(8'h0C, "R1 rise");
        clear_all();
        drive_in(32'h0, 18'h0, 2'b00, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0);
        rd_chk(8'h04, "R1 fall"); rd_chk(8'h0C, "R1 fall");
        irq_chk("R3 masked");

        // R5: rising-only sources ignore falling edges
        clear_all();
        drive_in(32'h0, 18'h0, 2'b00, 1'b1, 1'b1, 4'h0, 1'b1, 1'b1);
        rd_chk(8'h30, "R5 rise");
        clear_all();
        drive_in(32'h0, 18'h0, 2'b00, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0);
        rd_chk(8'h30, "R5 fall");

        // R8: latency of flags and comparator levels
        clear_all();
        @(negedge clk);
        g1_i[5] = 1'b1; cmp_i[0] = 1'b1;
        @(negedge clk); peek(8'h30, v); chk({28'b0, v[11:8]}, 32'h0, "R8 lvl edge1");
        @(negedge clk); peek(8'h30, v); chk({28'b0, v[11:8]}, 32'h1, "R8 lvl edge2");
        peek(8'h0C, v); chk(v, 32'h0, "R8 flag edge2");
        @(negedge clk); peek(8'h0C, v); chk(v, 32'h20, "R8 flag edge3");
        m_g1[5] = 1'b1; m_ps[4] = 1'b1;

        // R6: level bits ignore writes, flags survive a clear of bits 11:8
        wr(8'h30, 32'h0000_0F00);
        rd_chk(8'h30, "R6");

        // R9: event and clear on the same bit in the same cycle
        clear_all();
        drive_in(32'h2, g1_i, ls_i, vbus_i, dma_i, cmp_i, bb_i, rsd_i);
        @(negedge clk); g0_i[0] = 1'b1;
        @(negedge clk);
        @(negedge clk); addr = 8'h04; wdata = '1; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        m_g0 = 32'h1;
        rd_chk(8'h04, "R9");

        // R3 / R7 / R11 directed gating
        wr(8'h08, 32'h1);
        gwen = 1'b0; irq_chk("R3 glb off");
        gwen = 1'b1; irq_chk("R3 glb on");
        irq_chk("R11 held");
        wr(8'h04, 32'h1); irq_chk("R11 cleared");
        clear_all();
        drive_in(g0_i, g1_i, 2'b01, vbus_i, dma_i, cmp_i, 1'b0, 1'b0);
        drive_in(g0_i, g1_i, ls_i, vbus_i, dma_i, cmp_i, 1'b1, 1'b1);
        wr(8'h34, 32'hFF); uwen = 1'b0; irq_chk("R7 usb off");
        uwen = 1'b1; irq_chk("R7 usb on");
        wr(8'h30, 32'h3); irq_chk("R7 tail bits");
        rd_chk(8'h30, "R7");

        // random mix (R1 R2 R3 R5 R7 R11)
        for (int it = 0; it < 250; it++) begin
            drive_in(g0_i ^ ($urandom & $urandom & $urandom), g1_i ^ 18'($urandom & $urandom & $urandom),
                     ls_i ^ 2'($urandom % 4 == 0 ? $urandom : 0), vbus_i ^ ($urandom % 5 == 0),
                     dma_i ^ ($urandom % 4 == 0), cmp_i ^ 4'($urandom % 3 == 0 ? $urandom : 0),
                     bb_i ^ ($urandom % 6 == 0), rsd_i ^ ($urandom % 6 == 0));
            gwen = ($urandom % 4) != 0;
            uwen = ($urandom % 3) != 0;
            if ($urandom % 5 == 0) wr(8'h08, $urandom & $urandom);
            if ($urandom % 5 == 0) wr(8'h10, $urandom & $urandom);
            if ($urandom % 5 == 0) wr(8'h34, $urandom);
            case ($urandom % 3)
                0: wr(8'h04, $urandom);
                1: wr(8'h0C, $urandom);
                default: wr(8'h30, $urandom);
            endcase
            rd_chk(8'h04, "R1/R2 g0");
            rd_chk(8'h0C, "R1/R2 g1");
            rd_chk(8'h30, "R5/R6 periph");
            if (it % 10 == 0) begin
                rd_chk(8'h08, "R4 g0 en"); rd_chk(8'h10, "R4 g1 en"); rd_chk(8'h34, "R4 pr en");
            end
            irq_chk("R3/R7/R11 irq");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule